// File: doc/BRIEF.md
# Load/Store Region Router

This block stands between the load/store port of a small RISC-V core and three address regions: a read-only instruction memory, a word-organised data memory and a small memory-mapped I/O window. Every 32-bit byte address that the core presents goes to exactly one region, or to none. The block steers stores to the data memory with per-byte lane enables, keeps a 32-bit seven-segment display register inside the I/O window, and returns a full aligned 32-bit word for every load. The core does its own byte or half-word selection and sign or zero extension on loads.

The layout is set by parameters. Each region size is given as a count of byte-address bits, so a value of 9 gives 512 bytes, which is 128 words. The I/O window has no fixed address. It starts right after the data region, at the data base plus two to the power of the data width parameter. For sub-word stores the core must present a naturally aligned address, with the store data already placed in its byte lanes. The router only masks lanes and never shifts data.

A build option selects memories with synchronous reads. In that mode the instruction and data words arrive one clock after the address. The router then registers its region choice and its I/O read value, so that every read path has the same one-cycle latency.

Top module: `lsr_bus_router`

## Requirements
- R1: An address in [CODE_BASE, CODE_BASE + 2^CODE_AW) selects the instruction region. `code_waddr` carries address bits [CODE_AW-1:2], and a load returns `code_rdata`. Defaults: base 0x0000_0000, CODE_AW 9.
- R2: An address in [DATA_BASE, DATA_BASE + 2^DATA_AW) selects the data region. `data_waddr` carries address bits [DATA_AW-1:2], and a load returns `data_rdata`. Defaults: base 0x0000_2000, DATA_AW 9.
- R3: The I/O window starts at DATA_BASE + 2^DATA_AW (0x2200 by default) and spans 2^IO_AW bytes (16 by default). The word at offset 0 of the window is the display register, and loads return its value. Every other word in the window reads as zero.
- R4: A load from an address outside all three regions returns zero. A store to the instruction region, to an unmapped address or to any I/O word other than offset 0 drives `data_be` to 4'b0000 and leaves `seg_out` unchanged.
- R5: `cpu_size` is encoded as 2'b00 byte, 2'b01 half-word, 2'b10 word and 2'b11 reserved. A store into the data region drives `data_be` as follows. A byte store sets only bit addr[1:0]. A half-word store gives 4'b0011 when addr[1] is 0 and 4'b1100 when addr[1] is 1. A word store gives 4'b1111. The reserved size gives 4'b0000. `data_wdata` equals `cpu_wdata`, unshifted.
- R6: A store to the display word updates only the byte lanes enabled by the R5 rule. The new value shows on `seg_out` from the clock edge that takes the store.
- R7: With SYNC_RD = 1, the load result for an address presented in cycle N is on `cpu_rdata` during cycle N+1. The result follows the region of that earlier address, whatever address is presented in cycle N+1, and reads of the display word are delayed in the same way.
- R8: With SYNC_RD = 0, `cpu_rdata` follows the address presented in the same cycle, through logic only.
- R9: After reset, `seg_out` is zero and `data_be` is zero while no store is presented. With SYNC_RD = 1, `cpu_rdata` is zero in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_addr | input | 32 | Byte address from the core |
| cpu_we | input | 1 | Store request |
| cpu_size | input | 2 | Access size (00 byte, 01 half, 10 word) |
| cpu_wdata | input | 32 | Store data, already lane-aligned |
| cpu_rdata | output | 32 | Aligned load word back to the core |
| code_waddr | output | CODE_AW-2 | Word address to the instruction memory |
| code_rdata | input | 32 | Word from the instruction memory |
| data_waddr | output | DATA_AW-2 | Word address to the data memory |
| data_be | output | 4 | Byte-lane write enables for the data memory |
| data_wdata | output | 32 | Write data for the data memory |
| data_rdata | input | 32 | Word from the data memory |
| seg_out | output | 32 | Contents of the display register |

## Verification
In synchronous-read mode, the word for one load leaves the router in the same cycle in which the next access, load or store, is decoded against a possibly different region. The bench provokes this by following every load at once with an access to a randomly chosen other address. It then checks that the delayed word matches the value expected from the first address alone. It also runs random stores and loads over all regions and the unmapped gaps at once into a combinational-read instance and a synchronous-read instance. Both are judged against one shadow model of memory and display contents.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_CODE = 2'd1,
        RG_DATA = 2'd2,
        RG_IO   = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    localparam int LANES = 4;

endpackage

// File: rtl/lsr_decode.sv
module lsr_decode
    import lsr_pkg::*;
#(
    parameter logic [31:0] CODE_BASE = 32'h0000_0000,
    parameter int          CODE_AW   = 9,
    parameter logic [31:0] DATA_BASE = 32'h0000_2000,
    parameter int          DATA_AW   = 9,
    parameter int          IO_AW     = 4
) (
    input  logic [31:0] addr,
    output region_e     region,
    output logic        disp_hit
);
    localparam logic [31:0] IO_BASE   = DATA_BASE + (32'd1 << DATA_AW);
    localparam logic [31:0] CODE_SPAN = 32'd1 << CODE_AW;
    localparam logic [31:0] DATA_SPAN = 32'd1 << DATA_AW;
    localparam logic [31:0] IO_SPAN   = 32'd1 << IO_AW;

    logic [31:0] code_off, data_off, io_off;

    // Offsets wrap below the base, so one unsigned compare covers both ends.
    assign code_off = addr - CODE_BASE;
    assign data_off = addr - DATA_BASE;
    assign io_off   = addr - IO_BASE;

    always_comb begin
        region = RG_NONE;
        if (code_off < CODE_SPAN)      region = RG_CODE;
        else if (data_off < DATA_SPAN) region = RG_DATA;
        else if (io_off < IO_SPAN)     region = RG_IO;
    end

    assign disp_hit = (region == RG_IO) && (io_off < 32'd4);

endmodule

// File: rtl/lsr_lane_mask.sv
module lsr_lane_mask
    import lsr_pkg::*;
(
    input  size_e       size,
    input  logic [1:0]  addr_lo,
    output logic [LANES-1:0] lanes
);
    always_comb begin
        unique case (size)
            SZ_BYTE: lanes = 4'b0001 << addr_lo;
            SZ_HALF: lanes = addr_lo[1] ? 4'b1100 : 4'b0011;
            SZ_WORD: lanes = 4'b1111;
            SZ_RSVD: lanes = 4'b0000;
        endcase
    end

endmodule

// File: rtl/lsr_disp_reg.sv
module lsr_disp_reg
    import lsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LANES-1:0] lanes,
    input  logic [31:0]      wdata,
    output logic [31:0]      q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < LANES; k++) begin
                if (lanes[k]) q[k*8 +: 8] <= wdata[k*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/lsr_bus_router.sv
module lsr_bus_router
    import lsr_pkg::*;
#(
    parameter logic [31:0] CODE_BASE = 32'h0000_0000,
    parameter int          CODE_AW   = 9,
    parameter logic [31:0] DATA_BASE = 32'h0000_2000,
    parameter int          DATA_AW   = 9,
    parameter int          IO_AW     = 4,
    parameter bit          SYNC_RD   = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [31:0]          cpu_addr,
    input  logic                 cpu_we,
    input  logic [1:0]           cpu_size,
    input  logic [31:0]          cpu_wdata,
    output logic [31:0]          cpu_rdata,
    output logic [CODE_AW-3:0]   code_waddr,
    input  logic [31:0]          code_rdata,
    output logic [DATA_AW-3:0]   data_waddr,
    output logic [3:0]           data_be,
    output logic [31:0]          data_wdata,
    input  logic [31:0]          data_rdata,
    output logic [31:0]          seg_out
);
    region_e          cur_region;
    logic             disp_hit;
    logic [LANES-1:0] lanes;
    logic [31:0]      disp_q;
    region_e          rd_region;
    logic [31:0]      io_word;

    lsr_decode #(
        .CODE_BASE (CODE_BASE),
        .CODE_AW   (CODE_AW),
        .DATA_BASE (DATA_BASE),
        .DATA_AW   (DATA_AW),
        .IO_AW     (IO_AW)
    ) u_decode (
        .addr     (cpu_addr),
        .region   (cur_region),
        .disp_hit (disp_hit)
    );

    lsr_lane_mask u_lanes (
        .size    (size_e'(cpu_size)),
        .addr_lo (cpu_addr[1:0]),
        .lanes   (lanes)
    );

    lsr_disp_reg u_disp (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_we && disp_hit),
        .lanes (lanes),
        .wdata (cpu_wdata),
        .q     (disp_q)
    );

    assign code_waddr = cpu_addr[CODE_AW-1:2];
    assign data_waddr = cpu_addr[DATA_AW-1:2];
    assign data_wdata = cpu_wdata;
    assign data_be    = (cpu_we && cur_region == RG_DATA) ? lanes : 4'b0000;
    assign seg_out    = disp_q;

    // Read-side timing: either route by the current address or by the one
    // latched at the last edge, matching the memories' read latency.
    generate
        if (SYNC_RD) begin : g_sync
            region_e     region_q;
            logic [31:0] io_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    region_q <= RG_NONE;
                    io_q     <= '0;
                end else begin
                    region_q <= cur_region;
                    io_q     <= disp_hit ? disp_q : 32'd0;
                end
            end
            assign rd_region = region_q;
            assign io_word   = io_q;
        end else begin : g_comb
            assign rd_region = cur_region;
            assign io_word   = disp_hit ? disp_q : 32'd0;
        end
    endgenerate

    always_comb begin
        unique case (rd_region)
            RG_CODE: cpu_rdata = code_rdata;
            RG_DATA: cpu_rdata = data_rdata;
            RG_IO:   cpu_rdata = io_word;
            RG_NONE: cpu_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/lsr_bus_router_chk.sv
module lsr_bus_router_chk #(
    parameter logic [31:0] DATA_BASE = 32'h0000_2000,
    parameter int          DATA_AW   = 9,
    parameter int          IO_AW     = 4,
    parameter bit          SYNC_RD   = 1'b0
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] cpu_addr,
    input logic        cpu_we,
    input logic [1:0]  cpu_size,
    input logic [31:0] cpu_rdata,
    input logic [3:0]  data_be,
    input logic [31:0] seg_out
);
    localparam logic [31:0] IO_BASE = DATA_BASE + (32'd1 << DATA_AW);
    localparam logic [31:0] IO_END  = IO_BASE + (32'd1 << IO_AW);

    a_r5_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_size == 2'b00 |-> $onehot0(data_be));

    a_r5_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_size == 2'b01 && data_be != 4'b0000) |->
            (data_be == 4'b0011 || data_be == 4'b1100));

    a_r5_word_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_size == 2'b10 && data_be != 4'b0000) |-> data_be == 4'b1111);

    a_r5_rsvd_none: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_size == 2'b11 |-> data_be == 4'b0000);

    a_r4_be_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we |-> data_be == 4'b0000);

    a_r4_be_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        data_be != 4'b0000 |-> (cpu_addr >= DATA_BASE && cpu_addr < IO_BASE));

    a_r6_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_we |=> $stable(seg_out));

    generate
        if (SYNC_RD) begin : g_sync_chk
            a_r7_unmapped_late: assert property (@(posedge clk) disable iff (!rst_n)
                $past(cpu_addr) >= IO_END |-> cpu_rdata == 32'd0);
        end else begin : g_comb_chk
            a_r8_unmapped_now: assert property (@(posedge clk) disable iff (!rst_n)
                cpu_addr >= IO_END |-> cpu_rdata == 32'd0);
        end
    endgenerate

endmodule

bind lsr_bus_router lsr_bus_router_chk #(
    .DATA_BASE (DATA_BASE),
    .DATA_AW   (DATA_AW),
    .IO_AW     (IO_AW),
    .SYNC_RD   (SYNC_RD)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_we    (cpu_we),
    .cpu_size  (cpu_size),
    .cpu_rdata (cpu_rdata),
    .data_be   (data_be),
    .seg_out   (seg_out)
);

// File: tb/test_lsr_bus_router.sv
`timescale 1ns/1ps
module test_lsr_bus_router;

    localparam logic [31:0] CB   = 32'h0000_0000;
    localparam int          CAW  = 9;
    localparam logic [31:0] DB   = 32'h0000_2000;
    localparam int          DAW  = 9;
    localparam int          IOAW = 4;
    localparam logic [31:0] IOB  = DB + (32'd1 << DAW);
    localparam int          WDS  = 1 << (DAW - 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [31:0] addr = '0;
    logic        we = 1'b0;
    logic [1:0]  size = 2'b10;
    logic [31:0] wdata = '0;

    logic [31:0]    rdata_a, rdata_s;
    logic [CAW-3:0] cwa_a, cwa_s;
    logic [DAW-3:0] dwa_a, dwa_s;
    logic [3:0]     be_a, be_s;
    logic [31:0]    wd_a, wd_s, seg_a, seg_s;
    logic [31:0]    crd_a, crd_s, drd_a, drd_s;

    logic [31:0] ram_a [WDS];
    logic [31:0] ram_s [WDS];
    logic [31:0] shadow [WDS];
    logic [31:0] seg_shadow;

    int n_chk = 0;
    int n_err = 0;

    function automatic logic [31:0] rom_word(logic [CAW-3:0] w);
        return {16'hC0DE, 9'd0, w};
    endfunction

    function automatic logic [31:0] init_word(int i);
        return 32'hD00D_0000 + 32'(i);
    endfunction

    lsr_bus_router #(.CODE_BASE(CB), .CODE_AW(CAW), .DATA_BASE(DB), .DATA_AW(DAW),
                     .IO_AW(IOAW), .SYNC_RD(1'b0)) i_lsr_bus_router (
        .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_we(we), .cpu_size(size),
        .cpu_wdata(wdata), .cpu_rdata(rdata_a), .code_waddr(cwa_a), .code_rdata(crd_a),
        .data_waddr(dwa_a), .data_be(be_a), .data_wdata(wd_a), .data_rdata(drd_a),
        .seg_out(seg_a));

    lsr_bus_router #(.CODE_BASE(CB), .CODE_AW(CAW), .DATA_BASE(DB), .DATA_AW(DAW),
                     .IO_AW(IOAW), .SYNC_RD(1'b1)) i_lsr_bus_router_sr (
        .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_we(we), .cpu_size(size),
        .cpu_wdata(wdata), .cpu_rdata(rdata_s), .code_waddr(cwa_s), .code_rdata(crd_s),
        .data_waddr(dwa_s), .data_be(be_s), .data_wdata(wd_s), .data_rdata(drd_s),
        .seg_out(seg_s));

    // Memory models: combinational read for one instance, registered for the other.
    assign crd_a = rom_word(cwa_a);
    assign drd_a = ram_a[dwa_a];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WDS; i++) ram_a[i] <= init_word(i);
        end else begin
            for (int k = 0; k < 4; k++)
                if (be_a[k]) ram_a[dwa_a][k*8 +: 8] <= wd_a[k*8 +: 8];
        end
    end

    always @(posedge clk) begin
        crd_s <= rom_word(cwa_s);
        drd_s <= ram_s[dwa_s];
        if (!rst_n) begin
            for (int i = 0; i < WDS; i++) ram_s[i] <= init_word(i);
        end else begin
            for (int k = 0; k < 4; k++)
                if (be_s[k]) ram_s[dwa_s][k*8 +: 8] <= wd_s[k*8 +: 8];
        end
    end

    function automatic logic [3:0] exp_lanes(logic [1:0] sz, logic [1:0] lo);
        case (sz)
            2'b00:   return 4'b0001 << lo;
            2'b01:   return lo[1] ? 4'b1100 : 4'b0011;
            2'b10:   return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic bit in_data(logic [31:0] a);
        return a >= DB && a < IOB;
    endfunction

    function automatic bit in_disp(logic [31:0] a);
        return a >= IOB && a < IOB + 32'd4;
    endfunction

    function automatic logic [31:0] exp_read(logic [31:0] a);
        if (a - CB < (32'd1 << CAW)) return rom_word(a[CAW-1:2]);
        if (in_data(a))             return shadow[a[DAW-1:2]];
        if (in_disp(a))             return seg_shadow;
        return 32'd0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called just after a rising edge; returns just after the next one.
    task automatic do_write(logic [31:0] a, logic [1:0] sz, logic [31:0] d, string tag);
        logic [3:0] ln;
        ln = exp_lanes(sz, a[1:0]);
        addr = a; size = sz; wdata = d; we = 1'b1;
        @(negedge clk);
        chk({tag, " be comb"}, {28'd0, be_a}, in_data(a) ? {28'd0, ln} : 32'd0);
        chk({tag, " be sync"}, {28'd0, be_s}, in_data(a) ? {28'd0, ln} : 32'd0);
        chk("R5 wdata unshifted", wd_a, d);
        @(posedge clk); #1;
        we = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (ln[k] && in_data(a)) shadow[a[DAW-1:2]][k*8 +: 8] = d[k*8 +: 8];
            if (ln[k] && in_disp(a)) seg_shadow[k*8 +: 8] = d[k*8 +: 8];
        end
        chk({tag, " seg comb"}, seg_a, seg_shadow);
        chk({tag, " seg sync"}, seg_s, seg_shadow);
    endtask

    // Load check: comb result same cycle (R8), sync result one cycle later (R7)
    // while an unrelated access is already being decoded.
    task automatic do_read(logic [31:0] a, string tag);
        logic [31:0] e;
        e = exp_read(a);
        addr = a; we = 1'b0; size = 2'b10;
        @(negedge clk);
        chk({tag, " R8 comb"}, rdata_a, e);
        @(posedge clk); #1;
        addr = $urandom_range(0, 32'h2300);
        @(negedge clk);
        chk({tag, " R7 sync late"}, rdata_s, e);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < WDS; i++) shadow[i] = init_word(i);
        seg_shadow = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk("R9 seg comb after reset", seg_a, 32'd0);
        chk("R9 seg sync after reset", seg_s, 32'd0);
        chk("R9 sync rdata after reset", rdata_s, 32'd0);
        chk("R9 be idle", {28'd0, be_a}, 32'd0);
        @(posedge clk); #1;

        // Region boundaries
        do_read(32'h0000_0000, "R1 code base");
        do_read(32'h0000_01FC, "R1 code top");
        do_read(32'h0000_0200, "R4 code end+0");
        do_read(32'h0000_1FFF, "R4 data base-1");
        do_read(32'h0000_2000, "R2 data base");
        do_read(32'h0000_21FF, "R2 data last byte");
        do_read(32'h0000_21FC, "R2 io base-4");
        do_read(32'h0000_2200, "R3 disp word");
        do_read(32'h0000_220C, "R3 io spare word");
        do_read(32'h0000_2210, "R4 past io");
        do_read(32'hFFFF_0000, "R4 high address");

        // Lane masks into data word 5 and the display register
        for (int o = 0; o < 4; o++)
            do_write(DB + 32'h14 + 32'(o), 2'b00, 32'h11 << (8 * o), "R5 byte data");
        do_write(DB + 32'h14, 2'b01, 32'h0000_A5A5, "R5 half lo data");
        do_write(DB + 32'h16, 2'b01, 32'h5A5A_0000, "R5 half hi data");
        do_write(DB + 32'h18, 2'b10, 32'hCAFE_F00D, "R5 word data");
        do_write(DB + 32'h1C, 2'b11, 32'hFFFF_FFFF, "R5 reserved size");
        do_read(DB + 32'h14, "R2 readback lanes");
        do_read(DB + 32'h1C, "R5 reserved untouched");
        for (int o = 0; o < 4; o++)
            do_write(IOB + 32'(o), 2'b00, 32'h40 << (8 * o), "R6 byte disp");
        do_write(IOB + 32'h2, 2'b01, 32'h7E3C_0000, "R6 half disp");
        do_read(IOB, "R3 disp readback");
        do_write(IOB, 2'b10, 32'h0123_4567, "R6 word disp");

        // Stores that must be dropped
        do_write(32'h0000_0010, 2'b10, 32'hDEAD_BEEF, "R4 store to code");
        do_write(IOB + 32'h4, 2'b10, 32'hDEAD_BEEF, "R4 store io spare");
        do_write(32'h0000_3000, 2'b10, 32'hDEAD_BEEF, "R4 store unmapped");
        do_read(IOB, "R4 disp kept");

        // Random mix over all regions and gaps
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic [1:0]  sz;
            a  = $urandom_range(0, 32'h2300);
            sz = 2'($urandom_range(0, 3));
            if (sz == 2'b01) a[0] = 1'b0;
            if (sz == 2'b10) a[1:0] = 2'b00;
            if ($urandom_range(0, 1) == 1) do_write(a, sz, $urandom, "R5 random store");
            else                           do_read(a, "R1 random load");
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule